// File: doc/BRIEF.md
# Replay-Capable Strobed FIFO

This block is a single-clock first-in first-out store for 9-bit words whose depth is a power of two between 256 and 4096. A producer writes with an active-low write strobe. The word on `din` is captured when that strobe returns high. A consumer reads with an active-low read strobe. The oldest stored word is presented on `dout` when that strobe goes low. Both strobes are sampled on the system clock, and each edge becomes a one-cycle event. `dout_oe` marks when `dout` carries valid data, in place of a three-state driver.

Three active-low status flags are derived from a registered occupancy count: empty, full, and more-than-half full. A low level on the replay input moves the read position back to storage location zero and reloads the occupancy from the write position. Everything written since the last master reset can then be read again, and words written after the replay follow in order. A strobe edge that arrives while replay is low is dropped and reported on a one-cycle error output.

Top module: `retx_fifo`

## Requirements
- R1: While `mr_n` is low and after it is released, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `dout_oe` is 0.
- R2: A low-then-high pulse on `wr_n` stores `din` when `wr_n` is sampled high. A high-to-low edge on `rd_n` presents the oldest unread word on `dout` one clock later with `dout_oe` at 1, in write order.
- R3: A write edge while the store holds DEPTH words is dropped and the write position does not move. After draining, exactly the first DEPTH words come out.
- R4: A read edge while the store is empty is dropped. `dout_oe` stays 0 and the flags do not change.
- R5: `half_n` is 0 exactly when occupancy is at least DEPTH/2+1. A read from DEPTH/2+1 words to DEPTH/2 words returns it to 1.
- R6: `full_n` goes to 0 on the write that makes occupancy DEPTH, and returns to 1 after one accepted read.
- R7: `empty_n` goes to 0 when the last stored word is read, and returns to 1 after the first accepted write into the empty store.
- R8: A low level on `rt_n` sets the read position to location 0 and the occupancy to the number of writes since master reset. Later reads return the earliest words again, and the flags follow the new occupancy.
- R9: Words written after a replay are delivered after the replayed words, in write order.
- R10: `dout_oe` returns to 0 one clock after `rd_n` is sampled high.
- R11: A write or read strobe edge while `rt_n` is low is not performed. `proto_err` is 1 for the following clock only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mr_n | input | 1 | Master reset, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, capture on return high |
| rd_n | input | 1 | Read strobe, active low, read on fall |
| rt_n | input | 1 | Replay request, active low |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data |
| dout_oe | output | 1 | High while `dout` carries a read word |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |
| proto_err | output | 1 | One-cycle pulse for a strobe edge dropped during replay |

## Verification
The assertions check a set of properties on every clock. The occupancy always equals the distance between the write and read positions. No accepted write or read changes the occupancy at the full or empty bounds. The flags change on the exact crossing events. Replay always lands the read position on location zero, and `dout_oe` follows the read strobe. Only the bench scenarios can show that data comes out in order, that a drained full store returns exactly the first DEPTH words, and that a replay reproduces the earlier words followed by newer ones. The bench checks these with a reference list of accepted writes.

// File: rtl/retx_fifo_pkg.sv
`timescale 1ns/1ps
package retx_fifo_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

  // occupancy at which the half flag turns active
  function automatic int unsigned half_limit(int unsigned depth);
    return depth / 2 + 1;
  endfunction

  function automatic bit above_half(int unsigned occ, int unsigned depth);
    return occ >= half_limit(depth);
  endfunction

  // occupancy after one clock of accepted events
  function automatic int unsigned step_occ(int unsigned occ, bit inc, bit dec);
    return occ + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

endpackage

// File: rtl/retx_fifo_edge.sv
`timescale 1ns/1ps
module retx_fifo_edge #(
  parameter retx_fifo_pkg::edge_pol_e POL = retx_fifo_pkg::EDGE_RISE
) (
  input  logic clk,
  input  logic mr_n,
  input  logic strobe_n,
  output logic evt
);

  logic prev_q;

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n) prev_q <= 1'b1;
    else       prev_q <= strobe_n;
  end

  generate
    if (POL == retx_fifo_pkg::EDGE_RISE) begin : g_rise
      assign evt = ~prev_q & strobe_n;
    end else begin : g_fall
      assign evt = prev_q & ~strobe_n;
    end
  endgenerate

endmodule

// File: rtl/retx_fifo_ctrl.sv
`timescale 1ns/1ps
module retx_fifo_ctrl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned OW = AW + 1
) (
  input  logic          clk,
  input  logic          mr_n,
  input  logic          wr_evt,
  input  logic          rd_evt,
  input  logic          rt_n,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [OW-1:0] wptr,
  output logic [OW-1:0] rptr,
  output logic [OW-1:0] occ,
  output logic          proto_err
);
  import retx_fifo_pkg::*;

  localparam logic [OW-1:0] FULL_OCC = OW'(DEPTH);

  logic [OW-1:0] wptr_q, rptr_q, occ_q;
  logic          err_q;
  logic          rt_act;

  assign rt_act = ~rt_n;
  assign wr_acc = wr_evt & ~rt_act & (occ_q != FULL_OCC);
  assign rd_acc = rd_evt & ~rt_act & (occ_q != '0);

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= rt_act & (wr_evt | rd_evt);
      if (rt_act) begin
        // rewind: read position to location zero, count = write position - 0
        rptr_q <= '0;
        occ_q  <= wptr_q - OW'(0);
      end else begin
        if (wr_acc) wptr_q <= wptr_q + 1'b1;
        if (rd_acc) rptr_q <= rptr_q + 1'b1;
        occ_q <= OW'(step_occ(32'(occ_q), wr_acc, rd_acc));
      end
    end
  end

  assign wr_addr   = wptr_q[AW-1:0];
  assign rd_addr   = rptr_q[AW-1:0];
  assign wptr      = wptr_q;
  assign rptr      = rptr_q;
  assign occ       = occ_q;
  assign proto_err = err_q;

endmodule

// File: rtl/retx_fifo_store.sv
`timescale 1ns/1ps
module retx_fifo_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 9,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             mr_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n)   rdata_q <= '0;
    else if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/retx_fifo_flags.sv
`timescale 1ns/1ps
module retx_fifo_flags #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned OW = $clog2(DEPTH) + 1
) (
  input  logic [OW-1:0] occ,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  import retx_fifo_pkg::*;

  localparam logic [OW-1:0] FULL_OCC = OW'(DEPTH);

  always_comb begin
    empty_n = (occ != '0);
    full_n  = (occ != FULL_OCC);
    half_n  = ~above_half(32'(occ), DEPTH);
  end

endmodule

// File: rtl/retx_fifo.sv
`timescale 1ns/1ps
module retx_fifo #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             mr_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             proto_err
);
  import retx_fifo_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned OW = AW + 1;

  logic          wr_evt, rd_evt, wr_acc, rd_acc;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [OW-1:0] wptr, rptr, occ;
  logic          oe_q;

  retx_fifo_edge #(.POL(EDGE_RISE)) u_wr_edge (
    .clk(clk), .mr_n(mr_n), .strobe_n(wr_n), .evt(wr_evt)
  );

  retx_fifo_edge #(.POL(EDGE_FALL)) u_rd_edge (
    .clk(clk), .mr_n(mr_n), .strobe_n(rd_n), .evt(rd_evt)
  );

  retx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .mr_n(mr_n), .wr_evt(wr_evt), .rd_evt(rd_evt), .rt_n(rt_n),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .wptr(wptr), .rptr(rptr), .occ(occ), .proto_err(proto_err)
  );

  retx_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .mr_n(mr_n), .we(wr_acc), .waddr(wr_addr), .wdata(din),
    .re(rd_acc), .raddr(rd_addr), .rdata(dout)
  );

  retx_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .occ(occ), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n)       oe_q <= 1'b0;
    else if (rd_acc) oe_q <= 1'b1;
    else if (rd_n)   oe_q <= 1'b0;
  end

  assign dout_oe = oe_q;

endmodule

// File: rtl/retx_fifo_chk.sv
`timescale 1ns/1ps
module retx_fifo_chk #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned OW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          mr_n,
  input logic          rd_n,
  input logic          rt_n,
  input logic          dout_oe,
  input logic          empty_n,
  input logic          full_n,
  input logic          half_n,
  input logic          proto_err,
  input logic          wr_evt,
  input logic          rd_evt,
  input logic          wr_acc,
  input logic          rd_acc,
  input logic [OW-1:0] wptr,
  input logic [OW-1:0] rptr,
  input logic [OW-1:0] occ
);
  localparam logic [OW-1:0] HALF_OCC = OW'(DEPTH / 2);
  localparam logic [OW-1:0] LAST_OCC = OW'(DEPTH - 1);
  localparam logic [OW-1:0] ONE_OCC  = OW'(1);

  AST_OCC_TRACKS_PTRS: assert property (@(posedge clk) disable iff (!mr_n)
    occ == OW'(wptr - rptr)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!mr_n)
    (!full_n && wr_evt && !rd_evt && rt_n) |=> $stable(wptr) && !full_n); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!mr_n)
    (!empty_n && rd_evt) |=> !dout_oe && $stable(rptr)); // R4
  AST_HALF_SET: assert property (@(posedge clk) disable iff (!mr_n)
    (occ == HALF_OCC && wr_acc && !rd_acc && rt_n) |=> !half_n); // R5
  AST_FULL_SET: assert property (@(posedge clk) disable iff (!mr_n)
    (occ == LAST_OCC && wr_acc && !rd_acc && rt_n) |=> !full_n); // R6
  AST_EMPTY_SET: assert property (@(posedge clk) disable iff (!mr_n)
    (occ == ONE_OCC && rd_acc && !wr_acc && rt_n) |=> !empty_n); // R7
  AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (!mr_n)
    !rt_n |=> rptr == '0); // R8
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!mr_n)
    rd_n |=> !dout_oe); // R10
  AST_ERR_ONLY_IN_REPLAY: assert property (@(posedge clk) disable iff (!mr_n)
    proto_err |-> $past(!rt_n)); // R11
  AST_ERR_BLOCKS_OPS: assert property (@(posedge clk) disable iff (!mr_n)
    (!rt_n && (wr_evt || rd_evt)) |-> !wr_acc && !rd_acc); // R11
  AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!mr_n)
    !(!empty_n && !full_n)); // R6

endmodule

bind retx_fifo retx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .mr_n(mr_n), .rd_n(rd_n), .rt_n(rt_n), .dout_oe(dout_oe),
  .empty_n(empty_n), .full_n(full_n), .half_n(half_n), .proto_err(proto_err),
  .wr_evt(wr_evt), .rd_evt(rd_evt), .wr_acc(wr_acc), .rd_acc(rd_acc),
  .wptr(wptr), .rptr(rptr), .occ(occ)
);

// File: tb/retx_fifo_tb.sv
`timescale 1ns/1ps
module retx_fifo_tb;
  localparam int DEPTH = 16;
  localparam int WIDTH = 9;

  logic clk = 1'b0;
  logic mr_n = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic dout_oe, empty_n, full_n, half_n, proto_err;

  int n_tests = 0;
  int n_fail  = 0;

  logic [WIDTH-1:0] mdl[$];
  int mrd = 0;
  logic oe_seen = 1'b0;

  always #10 clk = ~clk;

  retx_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .mr_n(mr_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .empty_n(empty_n), .full_n(full_n),
    .half_n(half_n), .proto_err(proto_err)
  );

  function automatic int mcount();
    return mdl.size() - mrd;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_flags(string req);
    chk({req, " empty_n"}, int'(empty_n), int'(mcount() != 0));
    chk({req, " full_n"},  int'(full_n),  int'(mcount() != DEPTH));
    chk({req, " half_n"},  int'(half_n),  int'(!(mcount() >= DEPTH / 2 + 1)));
  endtask

  // monitor: each new read result is compared with the reference list
  always @(negedge clk) begin
    if (dout_oe && !oe_seen) begin
      if (mrd >= mdl.size()) begin
        n_tests++; n_fail++;
        $display("FAIL R2 unexpected read actual=%0h expected=none", dout);
      end else begin
        chk("R2/R8/R9 read data", int'(dout), int'(mdl[mrd]));
      end
      mrd++;
    end
    oe_seen = dout_oe;
  end

  task automatic do_reset();
    @(negedge clk);
    mr_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    @(negedge clk);
    chk("R1 empty_n in reset", int'(empty_n), 0);
    @(negedge clk);
    mr_n = 1'b1;
    mdl.delete(); mrd = 0;
    @(negedge clk);
  endtask

  task automatic do_write(logic [WIDTH-1:0] d);
    bit take;
    @(negedge clk);
    wr_n = 1'b0; din = d;
    @(negedge clk);
    wr_n = 1'b1;
    take = (mcount() < DEPTH);
    @(negedge clk);
    if (take) mdl.push_back(d);
  endtask

  task automatic do_read(string req);
    bit has;
    has = (mcount() > 0);
    @(negedge clk);
    rd_n = 1'b0;
    @(negedge clk);
    chk({req, " oe on read"}, int'(dout_oe), int'(has));
    rd_n = 1'b1;
    @(negedge clk);
    chk("R10 oe off after strobe high", int'(dout_oe), 0);
  endtask

  task automatic do_replay();
    @(negedge clk);
    rt_n = 1'b0;
    @(negedge clk);
    rt_n = 1'b1;
    mrd = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 empty_n", int'(empty_n), 0);
    chk("R1 full_n", int'(full_n), 1);
    chk("R1 half_n", int'(half_n), 1);
    chk("R1 dout_oe", int'(dout_oe), 0);

    // R4: read of an empty store
    do_read("R4");
    chk_flags("R4 after empty read");

    // R7 / R2: single word round trip
    do_write(9'h0A5);
    chk_flags("R7 after first write");
    do_read("R2");
    chk_flags("R7 after last read");

    // R5: half threshold both ways
    for (int i = 0; i < DEPTH / 2; i++) do_write(9'(i + 9'h010));
    chk_flags("R5 at half");
    do_write(9'h155);
    chk_flags("R5 at half plus one");
    do_read("R5");
    chk_flags("R5 back to half");

    // R6 / R3: fill, overrun, release
    while (mcount() < DEPTH) do_write(9'(mdl.size() + 9'h040));
    chk_flags("R6 full");
    do_write(9'h1AA);
    chk_flags("R3 after overrun");
    do_read("R6");
    chk_flags("R6 after read from full");
    while (mcount() > 0) do_read("R3");
    chk_flags("R3 drained");

    // R8 / R9: replay then new data
    do_reset();
    chk_flags("R1 after second reset");
    for (int i = 0; i < 5; i++) do_write(9'(9'h100 + i));
    for (int i = 0; i < 3; i++) do_read("R2");
    chk_flags("R8 before replay");
    do_replay();
    chk_flags("R8 after replay");
    do_write(9'h0F1);
    do_write(9'h0F2);
    while (mcount() > 0) do_read("R9");
    chk_flags("R9 drained");

    // R11: strobe edge while replay is low
    @(negedge clk);
    rt_n = 1'b0; wr_n = 1'b0; din = 9'h033;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    chk("R11 proto_err pulse", int'(proto_err), 1);
    rt_n = 1'b1;
    mrd = 0;
    @(negedge clk);
    chk("R11 proto_err clears", int'(proto_err), 0);
    chk_flags("R11 write dropped");
    while (mcount() > 0) do_read("R11");
    chk_flags("R11 drained");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule